// File: doc/BRIEF.md
# Conflict-Free Parallel Memory Access Unit

This block sits between four processing lanes of a video coding datapath and eight single-port memory banks. Pixel storage is seen as three independent two-dimensional coordinate areas. Two split areas own four banks each (the low group and the high group), and one shared area spreads over all eight banks. Each 4-element access names a start coordinate and a shape. The block works out which bank and which word every element lives in, steers write data from lane order into bank order, and steers read data from bank order back into lane order. Because of the skewed storage mapping, every supported shape touches four different banks, so a whole access completes in one cycle.

Two request slots exist. Slot 0 serves split area 0 and slot 1 serves split area 1, and both may proceed in the same cycle. Either slot may instead address the shared area by raising its shared flag. In that case the shared access owns all eight banks, so the other slot cannot proceed in that cycle. Requests use valid/ready. Slot 0 is always ready. Slot 1 drops ready, and `stall` reports the refusal, whenever slot 0 is valid and either slot asks for the shared area. A refused slot must hold its request until ready. Responses carry no back-pressure: a response appears exactly one cycle after acceptance and must be taken by the consumer in that cycle.

Area geometry is set by parameters. The split areas have widths L0 and L1, which must be multiples of 4, and top word addresses A0MAX and A1MAX. The shared area has width L2, which must be a multiple of 8, and starts in every bank at the word above the larger of A0MAX and A1MAX. Area heights are derived from these values.

Top module: `pmem_access_unit`

## Requirements
- R1: `req_ready[0]` is always 1. `req_ready[1]` is 0 exactly when `req_valid[0]` is 1 and at least one of `req_shared[0]` or `req_shared[1]` is 1. `stall` equals `req_valid[1] & ~req_ready[1]`.
- R2: With neither shared flag set, slot 0 (area 0, banks 0-3) and slot 1 (area 1, banks 4-7) are both accepted in the same cycle. Neither disturbs the other's data.
- R3: An element written at coordinate (x,y) of an area is returned unchanged by any later error-free read that covers (x,y) in the same area, whatever shapes the write and the read used. Every error-free access uses four distinct banks.
- R4: `req_fmt` encodes the shape, with element k on lane k starting from (i,j). Code 0 is a row, giving (i+k, j). Code 1 is a column, giving (i, j+k). Code 2 is a diagonal, giving (i+k, j+k). Code 3 is an anti-diagonal, giving (i-k, j+k).
- R5: The shared area accepts all four shapes. Its storage is separate from areas 0 and 1: writes to either side never change what the other side reads.
- R6: A request accepted in cycle t gives `rsp_valid` for that slot in cycle t+1 only. For a read, lane k of `rsp_data` then holds element k.
- R7: A diagonal or anti-diagonal request (codes 2 or 3) to a split area gives `rsp_err`=1 and writes no bank.
- R8: A request in which any element lies outside its area (x<0, x>=width or y>=height) gives `rsp_err`=1 and writes no bank.
- R9: When slot 0 uses the shared area, or slot 1 asks for it while slot 0 is valid, slot 1 is refused with `stall` and slot 0 proceeds.
- R10: An accepted error-free write is acknowledged with `rsp_valid`=1 and `rsp_err`=0 one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 2 | Request valid, one bit per slot |
| req_ready | output | 2 | Request ready, one bit per slot |
| req_shared | input | 2 | Slot addresses the shared area instead of its split area |
| req_we | input | 2 | 1 = write, 0 = read, per slot |
| req_fmt | input | 2x2 | Access shape code per slot |
| req_i | input | 2xCW | Start horizontal coordinate per slot |
| req_j | input | 2xCW | Start vertical coordinate per slot |
| req_wdata | input | 2x4xDW | Write data, lane order, per slot |
| stall | output | 1 | Slot 1 request refused this cycle |
| rsp_valid | output | 2 | Response valid per slot |
| rsp_err | output | 2 | Response carries a rejected request |
| rsp_data | output | 2x4xDW | Read data, lane order, per slot |

## Verification
The two functions that share a cycle are slot 0 and slot 1, which contend for the banks. Random traffic drives both slots at once with mixed shared flags, shapes and slightly out-of-range coordinates. This provokes dual split-area accesses and shared-area collisions, along with directed cases for each collision type. Each cycle the bench predicts slot 1 readiness and `stall` from the slot inputs. It predicts which slots answer next cycle and with what error flag, and it checks read data against a per-area storage model updated only by accepted error-free writes.

// File: rtl/pmem_pkg.sv
package pmem_pkg;
  localparam int NLANE  = 4;
  localparam int NBANK  = 8;
  localparam int BANK_W = $clog2(NBANK);

  typedef enum logic [1:0] {
    FMT_ROW  = 2'd0,
    FMT_COL  = 2'd1,
    FMT_DIAG = 2'd2,
    FMT_ANTI = 2'd3
  } fmt_e;
endpackage

// File: rtl/pmem_bank.sv
module pmem_bank #(
  parameter int DW = 8,
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          en,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/pmem_addr_gen.sv
// Per-slot element locator: coordinates, bounds, bank and word per lane.
module pmem_addr_gen
  import pmem_pkg::*;
#(
  parameter int CW    = 6,
  parameter int AW    = 6,
  parameter int LS    = 16,
  parameter int HS    = 8,
  parameter int GROUP = 0,
  parameter int L2    = 32,
  parameter int H2    = 8,
  parameter int BASE2 = 32
) (
  input  logic                        shared,
  input  logic [1:0]                  fmt,
  input  logic [CW-1:0]               ci,
  input  logic [CW-1:0]               cj,
  output logic [NLANE-1:0][BANK_W-1:0] bank_o,
  output logic [NLANE-1:0][AW-1:0]    addr_o,
  output logic                        err_o
);
  localparam int EW  = CW + 2;
  localparam int LNW = AW + 3;

  logic [NLANE-1:0] inb;

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    logic [EW-1:0]  ex, ey;
    logic [LNW-1:0] lin;

    always_comb begin
      case (fmt_e'(fmt))
        FMT_ROW:  begin ex = EW'(ci) + EW'(k); ey = EW'(cj);          end
        FMT_COL:  begin ex = EW'(ci);          ey = EW'(cj) + EW'(k); end
        FMT_DIAG: begin ex = EW'(ci) + EW'(k); ey = EW'(cj) + EW'(k); end
        default:  begin ex = EW'(ci) - EW'(k); ey = EW'(cj) + EW'(k); end
      endcase
      if (shared) begin
        inb[k]    = (ex < EW'(L2)) && (ey < EW'(H2));
        lin       = LNW'(ey) * LNW'(L2) + LNW'(ex);
        addr_o[k] = AW'(BASE2) + AW'(lin >> 3);
        bank_o[k] = BANK_W'(ex + (ey << 1));
      end else begin
        inb[k]    = (ex < EW'(LS)) && (ey < EW'(HS));
        lin       = LNW'(ey) * LNW'(LS) + LNW'(ex);
        addr_o[k] = AW'(lin >> 2);
        bank_o[k] = BANK_W'(GROUP * 4) + BANK_W'(2'(ex + ey));
      end
    end
  end

  assign err_o = (!shared && fmt[1]) || !(&inb);
endmodule

// File: rtl/pmem_rsp_xbar.sv
// Undoes the bank permutation: lane k of each slot picks its recorded bank.
module pmem_rsp_xbar
  import pmem_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [NBANK-1:0][DW-1:0]            bank_rd,
  input  logic [1:0][NLANE-1:0][BANK_W-1:0]   sel,
  output logic [1:0][NLANE-1:0][DW-1:0]       lane_rd
);
  for (genvar s = 0; s < 2; s++) begin : g_slot
    for (genvar k = 0; k < NLANE; k++) begin : g_lane
      assign lane_rd[s][k] = bank_rd[sel[s][k]];
    end
  end
endmodule

// File: rtl/pmem_access_unit.sv
module pmem_access_unit
  import pmem_pkg::*;
#(
  parameter int DW    = 8,
  parameter int CW    = 6,
  parameter int AW    = 6,
  parameter int L0    = 16,
  parameter int L1    = 16,
  parameter int L2    = 32,
  parameter int A0MAX = 31,
  parameter int A1MAX = 31
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   req_valid,
  output logic [1:0]                   req_ready,
  input  logic [1:0]                   req_shared,
  input  logic [1:0]                   req_we,
  input  logic [1:0][1:0]              req_fmt,
  input  logic [1:0][CW-1:0]           req_i,
  input  logic [1:0][CW-1:0]           req_j,
  input  logic [1:0][NLANE-1:0][DW-1:0] req_wdata,
  output logic                         stall,
  output logic [1:0]                   rsp_valid,
  output logic [1:0]                   rsp_err,
  output logic [1:0][NLANE-1:0][DW-1:0] rsp_data
);
  localparam int BASE2 = ((A0MAX > A1MAX) ? A0MAX : A1MAX) + 1;
  localparam int H0    = 4 * (A0MAX + 1) / L0;
  localparam int H1    = 4 * (A1MAX + 1) / L1;
  localparam int H2    = NBANK * ((1 << AW) - BASE2) / L2;

  logic [1:0][NLANE-1:0][BANK_W-1:0] bank_sel, sel_q;
  logic [1:0][NLANE-1:0][AW-1:0]     lane_addr;
  logic [1:0]                        err, accept, fire;

  logic [NBANK-1:0]                  bank_en, bank_we;
  logic [NBANK-1:0][AW-1:0]          bank_addr;
  logic [NBANK-1:0][DW-1:0]          bank_wd, bank_rd;

  // Slot 0 has priority; the shared area excludes any second access.
  assign req_ready[0] = 1'b1;
  assign req_ready[1] = !(req_valid[0] && (req_shared[0] || req_shared[1]));
  assign stall        = req_valid[1] && !req_ready[1];

  for (genvar s = 0; s < 2; s++) begin : g_slot
    pmem_addr_gen #(
      .CW(CW), .AW(AW),
      .LS((s == 0) ? L0 : L1), .HS((s == 0) ? H0 : H1),
      .GROUP(s), .L2(L2), .H2(H2), .BASE2(BASE2)
    ) u_gen (
      .shared (req_shared[s]),
      .fmt    (req_fmt[s]),
      .ci     (req_i[s]),
      .cj     (req_j[s]),
      .bank_o (bank_sel[s]),
      .addr_o (lane_addr[s]),
      .err_o  (err[s])
    );
    assign accept[s] = req_valid[s] && req_ready[s];
    assign fire[s]   = accept[s] && !err[s];
  end

  // Forward crossbar: lane order to bank order.
  always_comb begin
    bank_en   = '0;
    bank_we   = '0;
    bank_addr = '0;
    bank_wd   = '0;
    for (int b = 0; b < NBANK; b++) begin
      for (int s = 0; s < 2; s++) begin
        for (int k = 0; k < NLANE; k++) begin
          if (fire[s] && bank_sel[s][k] == BANK_W'(b)) begin
            bank_en[b]   = 1'b1;
            bank_we[b]   = req_we[s];
            bank_addr[b] = lane_addr[s][k];
            bank_wd[b]   = req_wdata[s][k];
          end
        end
      end
    end
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    pmem_bank #(.DW(DW), .AW(AW)) u_bank (
      .clk   (clk),
      .en    (bank_en[b]),
      .we    (bank_we[b]),
      .addr  (bank_addr[b]),
      .wdata (bank_wd[b]),
      .rdata (bank_rd[b])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= '0;
      rsp_err   <= '0;
      sel_q     <= '0;
    end else begin
      rsp_valid <= accept;
      rsp_err   <= accept & err;
      sel_q     <= bank_sel;
    end
  end

  pmem_rsp_xbar #(.DW(DW)) u_xbar (
    .bank_rd (bank_rd),
    .sel     (sel_q),
    .lane_rd (rsp_data)
  );
endmodule

// File: rtl/pmem_access_unit_chk.sv
module pmem_access_unit_chk #(
  parameter int NB = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic [1:0]    req_valid,
  input logic [1:0]    req_ready,
  input logic [1:0]    req_shared,
  input logic [1:0][1:0] req_fmt,
  input logic          stall,
  input logic [1:0]    rsp_valid,
  input logic [NB-1:0] bank_en
);
  p_stall_on_shared_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid[0] && req_valid[1] && (req_shared[0] || req_shared[1])) |-> stall);

  p_rsp_next_s0_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid[0] && req_ready[0]) |=> rsp_valid[0]);

  p_rsp_next_s1_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid[1] && req_ready[1]) |=> rsp_valid[1]);

  p_no_spurious_rsp_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid[1] && req_ready[1]) |=> !rsp_valid[1]);

  p_bad_fmt_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid[0] && !req_valid[1] && !req_shared[0] && req_fmt[0][1]) |-> (bank_en == '0));

  p_area0_low_group_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid[0] && !req_valid[1] && !req_shared[0]) |-> (bank_en[NB-1:NB/2] == '0));

  p_bank_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_en == '0) || ($countones(bank_en) == 4) || ($countones(bank_en) == 8));
endmodule

bind pmem_access_unit pmem_access_unit_chk #(.NB(pmem_pkg::NBANK)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .req_shared (req_shared),
  .req_fmt    (req_fmt),
  .stall      (stall),
  .rsp_valid  (rsp_valid),
  .bank_en    (bank_en)
);

// File: tb/pmem_access_unit_test.sv
`timescale 1ns/1ps
module pmem_access_unit_test;
  localparam int DW = 8, CW = 6, AW = 6;
  localparam int L0 = 16, L1 = 16, L2 = 32;
  localparam int H0 = 8, H1 = 8, H2 = 8;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic [1:0]             req_valid = '0, req_ready, req_shared = '0, req_we = '0;
  logic [1:0][1:0]        req_fmt = '0;
  logic [1:0][CW-1:0]     req_i = '0, req_j = '0;
  logic [1:0][3:0][DW-1:0] req_wdata = '0;
  logic                   stall;
  logic [1:0]             rsp_valid, rsp_err;
  logic [1:0][3:0][DW-1:0] rsp_data;

  pmem_access_unit #(.DW(DW), .CW(CW), .AW(AW), .L0(L0), .L1(L1), .L2(L2),
                     .A0MAX(31), .A1MAX(31)) uut (.*);

  always #2 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] m0 [H0][L0];
  logic [DW-1:0] m1 [H1][L1];
  logic [DW-1:0] m2 [H2][L2];

  bit pv[2], psh[2], pwe[2];
  int pf[2], pi[2], pj[2];
  logic [DW-1:0] pw[2][4];

  task automatic chk(input bit ok, input string rq, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic int ex_of(int i, int f, int k);
    return (f == 1) ? i : (f == 3) ? i - k : i + k;
  endfunction
  function automatic int ey_of(int j, int f, int k);
    return (f == 0) ? j : j + k;
  endfunction
  function automatic int area_w(int a);
    return (a == 0) ? L0 : (a == 1) ? L1 : L2;
  endfunction
  function automatic int area_h(int a);
    return (a == 0) ? H0 : (a == 1) ? H1 : H2;
  endfunction
  function automatic logic [DW-1:0] mget(int a, int x, int y);
    return (a == 0) ? m0[y][x] : (a == 1) ? m1[y][x] : m2[y][x];
  endfunction
  task automatic mput(int a, int x, int y, logic [DW-1:0] v);
    if (a == 0) m0[y][x] = v; else if (a == 1) m1[y][x] = v; else m2[y][x] = v;
  endtask
  // 0 = fine, 1 = unsupported shape (R7), 2 = out of area (R8)
  function automatic int err_cause(int a, int f, int i, int j);
    if (a != 2 && f >= 2) return 1;
    for (int k = 0; k < 4; k++) begin
      int x = ex_of(i, f, k), y = ey_of(j, f, k);
      if (x < 0 || x >= area_w(a) || y >= area_h(a)) return 2;
    end
    return 0;
  endfunction

  task automatic set_req(int s, bit v, bit sh, bit we, int f, int i, int j);
    pv[s] = v; psh[s] = sh; pwe[s] = we; pf[s] = f; pi[s] = i; pj[s] = j;
    for (int k = 0; k < 4; k++) pw[s][k] = DW'($urandom);
  endtask

  // Starts at a negedge, ends at the next negedge.
  task automatic cycle();
    bit exp_r1, acc[2];
    int cause[2], area[2];
    logic [DW-1:0] exp_rd[2][4];
    for (int s = 0; s < 2; s++) begin
      req_valid[s] = pv[s]; req_shared[s] = psh[s]; req_we[s] = pwe[s];
      req_fmt[s] = 2'(pf[s]); req_i[s] = CW'(pi[s]); req_j[s] = CW'(pj[s]);
      for (int k = 0; k < 4; k++) req_wdata[s][k] = pw[s][k];
    end
    #1;
    exp_r1 = !(pv[0] && (psh[0] || psh[1]));
    chk(req_ready[0] == 1'b1, "R1 ready0", req_ready[0], 1);
    chk(req_ready[1] == exp_r1, "R1 ready1", req_ready[1], exp_r1);
    chk(stall == (pv[1] && !exp_r1), "R9 stall", stall, pv[1] && !exp_r1);
    acc[0] = pv[0];
    acc[1] = pv[1] && exp_r1;
    for (int s = 0; s < 2; s++) begin
      area[s]  = psh[s] ? 2 : s;
      cause[s] = err_cause(area[s], pf[s], pi[s], pj[s]);
      for (int k = 0; k < 4; k++)
        if (acc[s] && cause[s] == 0 && !pwe[s])
          exp_rd[s][k] = mget(area[s], ex_of(pi[s], pf[s], k), ey_of(pj[s], pf[s], k));
    end
    for (int s = 0; s < 2; s++)
      if (acc[s] && cause[s] == 0 && pwe[s])
        for (int k = 0; k < 4; k++)
          mput(area[s], ex_of(pi[s], pf[s], k), ey_of(pj[s], pf[s], k), pw[s][k]);
    @(posedge clk); #1;
    req_valid = '0;
    @(negedge clk);
    for (int s = 0; s < 2; s++) begin
      chk(rsp_valid[s] == acc[s], (acc[0] && acc[1]) ? "R2 dual rsp" : "R6 rsp_valid",
          rsp_valid[s], acc[s]);
      if (acc[s]) begin
        bit e = (cause[s] != 0);
        chk(rsp_err[s] == e, (cause[s] == 1) ? "R7 err" : (cause[s] == 2) ? "R8 err" :
            pwe[s] ? "R10 ack" : "R6 err", rsp_err[s], e);
        if (!e && !pwe[s])
          for (int k = 0; k < 4; k++)
            chk(rsp_data[s][k] == exp_rd[s][k],
                psh[s] ? "R5 rdata" : (pf[s] == 0) ? "R3 rdata" : "R4 rdata",
                rsp_data[s][k], exp_rd[s][k]);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=expired expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    chk(rsp_valid == 2'b00, "R6 reset rsp_valid", rsp_valid, 0);
    chk(req_ready[0] == 1'b1, "R1 reset ready0", req_ready[0], 1);
    rst_n = 1'b1;
    @(negedge clk);

    // Fill both split areas concurrently (R2, R10), then the shared area.
    for (int y = 0; y < H0; y++)
      for (int x = 0; x < L0; x += 4) begin
        set_req(0, 1, 0, 1, 0, x, y);
        set_req(1, 1, 0, 1, 0, x, y);
        cycle();
      end
    for (int y = 0; y < H2; y++)
      for (int x = 0; x < L2; x += 4) begin
        set_req(0, 1, 1, 1, 0, x, y);
        set_req(1, 0, 0, 0, 0, 0, 0);
        cycle();
      end

    // R2: dual read, row in area 0 and column in area 1.
    set_req(0, 1, 0, 0, 0, 4, 2); set_req(1, 1, 0, 0, 1, 7, 3); cycle();
    // R7: diagonal write into area 0 rejected, then read back unchanged.
    set_req(0, 1, 0, 1, 2, 0, 0); set_req(1, 0, 0, 0, 0, 0, 0); cycle();
    set_req(0, 1, 0, 0, 0, 0, 0); cycle();
    set_req(0, 1, 0, 0, 0, 0, 1); cycle();
    // R8: anti-diagonal leaving the left edge; column leaving the bottom.
    set_req(0, 1, 1, 1, 3, 2, 0); cycle();
    set_req(0, 1, 0, 1, 1, 5, H0 - 3); cycle();
    set_req(0, 1, 1, 0, 3, 2, 0); cycle();
    // R9: shared slot 0 against a slot 1 request; slot 1 asking shared.
    set_req(0, 1, 1, 1, 2, 3, 1); set_req(1, 1, 0, 0, 0, 0, 0); cycle();
    set_req(0, 1, 0, 0, 0, 0, 0); set_req(1, 1, 1, 0, 1, 0, 0); cycle();
    // R5: shared area shapes after the writes above.
    set_req(1, 0, 0, 0, 0, 0, 0);
    for (int f = 0; f < 4; f++) begin
      set_req(0, 1, 1, 0, f, 3 + f, 1); cycle();
    end

    // Constrained random traffic on both slots.
    for (int n = 0; n < 3000; n++) begin
      for (int s = 0; s < 2; s++) begin
        bit sh = ($urandom % 5) == 0;
        int a = sh ? 2 : s;
        set_req(s, ($urandom % 4) != 0, sh, $urandom % 2, $urandom % 4,
                $urandom % (area_w(a) + 2), $urandom % (area_h(a) + 2));
      end
      cycle();
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule